// File: doc/BRIEF.md
# Data Access Translation and Protection Checker

This block sits in a load/store path between the address generator and a unified TLB. For every data access it decides whether the virtual address goes to the TLB, passes through unchanged, or is refused. It checks alignment against the access size, the rules on which address regions user code may reach, and the store-queue window. After a TLB hit it checks the two-bit page protection field and the page dirty bit. The result is a physical address or an exception event code with a vector offset.

The TLB lookup runs in the same cycle as the request: the block raises `tlb_use` when it needs the TLB answer and reads the hit, multihit, physical address, protection and dirty inputs in that cycle. The response is registered and appears one cycle after the request. Any refusal also loads a fault-address register and a page-number register. These are the values a trap handler reads. Taking the exception is left to the core.

Top module: `dac_xlate_check`

## Requirements
- R1: `req_size` codes 0, 1, 2 and 3 mean 1, 2, 4 and 8 bytes. An address that is not a multiple of the access size is an address error. This check comes before every other check.
- R2: In user mode (`priv_mode`=0), an address with bit 31 set is an address error. The one exception is a write into the store-queue window 0xE0000000 to 0xE3FFFFFF.
- R3: In privileged mode, addresses 0x7C000000 to 0x7FFFFFFF pass through with the physical address equal to the virtual address, and `tlb_use` stays low.
- R4: When address bits 31:29 are 100, 101 or 111 and no earlier rule applies, the access passes through untranslated.
- R5: Any other address is translated when `xlate_en`=1. A TLB miss is a miss error, and a hit returns `tlb_paddr`. When `xlate_en`=0 the address passes through.
- R6: After a TLB hit, the protection checks apply in this order. `tlb_prot[1]`=0 in user mode is a protection error. On a write, `tlb_prot[0]`=0 is a protection error. On a write with `tlb_prot[0]`=1 and `tlb_dirty`=0, the result is a first-write error.
- R7: A store-queue write needs address bits 1:0 equal to 0, and it is refused in user mode when `sq_priv_only`=1. Both cases are address errors. With translation off, the result is `sq_base1` if address bit 5 is set, else `sq_base0`, plus the address with bits 4:0 cleared (32-bit sum). With translation on, the result is `tlb_paddr` with bits 4:0 cleared, after the R6 checks.
- R8: Write fault codes and vector offsets are: miss 0x060/0x400, protection 0x0C0/0x100, first write 0x080/0x100, address error 0x100/0x100.
- R9: Read fault codes and vector offsets are: miss 0x040/0x400, protection 0x0A0/0x100, address error 0x0E0/0x100.
- R10: Every fault or multihit loads `fault_addr` with the virtual address and `fault_vpn` with its bits 31:10. All other responses leave both registers unchanged.
- R11: A TLB multihit (`tlb_multi`=1, which takes priority over `tlb_hit`) raises `rsp_multihit` with `rsp_fault`=0, code 0 and vector 0. On any fault or multihit, `rsp_paddr` is 0.
- R12: `rsp_valid` and the result follow `req_valid` one clock later. After reset every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Access request present |
| req_vaddr | input | 32 | Virtual address |
| req_size | input | 2 | Access size code (1/2/4/8 bytes) |
| req_write | input | 1 | 1 = store, 0 = load |
| priv_mode | input | 1 | 1 = privileged mode |
| xlate_en | input | 1 | Address translation enabled |
| sq_priv_only | input | 1 | Store-queue window restricted to privileged mode |
| sq_base0 | input | 32 | Store-queue target base, address bit 5 clear |
| sq_base1 | input | 32 | Store-queue target base, address bit 5 set |
| tlb_hit | input | 1 | TLB found a matching entry |
| tlb_multi | input | 1 | TLB found more than one matching entry |
| tlb_paddr | input | 32 | Translated physical address from the TLB |
| tlb_prot | input | 2 | Page protection: bit 1 user access, bit 0 write allowed |
| tlb_dirty | input | 1 | Page already written |
| tlb_use | output | 1 | Combinational: this request needs the TLB result |
| rsp_valid | output | 1 | Response present |
| rsp_paddr | output | 32 | Physical address (0 on a fault) |
| rsp_fault | output | 1 | Exception raised |
| rsp_multihit | output | 1 | TLB multihit reported |
| rsp_code | output | 12 | Exception event code |
| rsp_vec | output | 12 | Exception vector offset |
| fault_addr | output | 32 | Last faulting virtual address |
| fault_vpn | output | 22 | Bits 31:10 of the last faulting address |

## Verification
A wrong route decision shows up in the very next response. It appears either as a physical address that should have been the virtual one or the TLB's, or as a fault code whose value names the error class, so a misrouted region is caught on its first access. A wrong ordering of the protection checks shows up as a first-write code where a protection code was due. A fault-address register that updates or fails to update is caught by comparing it after every response against an expected value that the bench tracks across the whole run.

// File: rtl/dac_pkg.sv
package dac_pkg;

    typedef enum logic [2:0] {
        ERR_NONE,
        ERR_MISS,
        ERR_MHIT,
        ERR_PROT,
        ERR_FWR,
        ERR_ADDR
    } dac_err_e;

    typedef enum logic [1:0] {
        RT_PASS,
        RT_TLB,
        RT_SQ,
        RT_ERR
    } dac_route_e;

    localparam logic [5:0] SQ_WIN_TAG   = 6'b111000;
    localparam logic [5:0] PRIV_RAW_TAG = 6'b011111;

endpackage

// File: rtl/dac_region.sv
module dac_region
    import dac_pkg::*;
#(
    parameter int AW = 32
) (
    input  logic [AW-1:0] vaddr,
    input  logic [1:0]    size,
    input  logic          is_write,
    input  logic          priv,
    input  logic          sq_priv_only,
    output dac_route_e    route
);
    localparam int TOP = AW - 1;

    logic [2:0] low_mask;
    logic       misaligned;
    logic       in_sq;
    logic       in_raw;
    logic       bypass_seg;

    always_comb begin
        case (size)
            2'd0:    low_mask = 3'b000;
            2'd1:    low_mask = 3'b001;
            2'd2:    low_mask = 3'b011;
            default: low_mask = 3'b111;
        endcase
        misaligned = |(vaddr[2:0] & low_mask);
        in_sq      = (vaddr[TOP -: 6] == SQ_WIN_TAG);
        in_raw     = (vaddr[TOP -: 6] == PRIV_RAW_TAG);
        bypass_seg = (vaddr[TOP -: 3] == 3'b100) || (vaddr[TOP -: 3] == 3'b101) ||
                     (vaddr[TOP -: 3] == 3'b111);

        if (misaligned) begin
            route = RT_ERR;
        end else if (is_write && in_sq) begin
            if ((vaddr[1:0] != 2'b00) || (sq_priv_only && !priv)) route = RT_ERR;
            else                                                   route = RT_SQ;
        end else if (!priv && vaddr[TOP]) begin
            route = RT_ERR;
        end else if (priv && in_raw) begin
            route = RT_PASS;
        end else if (bypass_seg) begin
            route = RT_PASS;
        end else begin
            route = RT_TLB;
        end
    end
endmodule

// File: rtl/dac_prot.sv
module dac_prot
    import dac_pkg::*;
(
    input  logic       hit,
    input  logic       multi,
    input  logic [1:0] prot,
    input  logic       dirty,
    input  logic       priv,
    input  logic       is_write,
    output dac_err_e   err
);
    always_comb begin
        if (multi)                        err = ERR_MHIT;
        else if (!hit)                    err = ERR_MISS;
        else if (!prot[1] && !priv)       err = ERR_PROT;
        else if (is_write && !prot[0])    err = ERR_PROT;
        else if (is_write && !dirty)      err = ERR_FWR;
        else                              err = ERR_NONE;
    end
endmodule

// File: rtl/dac_exc_map.sv
module dac_exc_map
    import dac_pkg::*;
#(
    parameter int CW = 12
) (
    input  dac_err_e      err,
    input  logic          is_write,
    output logic [CW-1:0] code,
    output logic [CW-1:0] vec
);
    localparam logic [CW-1:0] VEC_MISS  = CW'(12'h400);
    localparam logic [CW-1:0] VEC_OTHER = CW'(12'h100);

    always_comb begin
        code = '0;
        vec  = '0;
        case (err)
            ERR_MISS: begin
                code = is_write ? CW'(12'h060) : CW'(12'h040);
                vec  = VEC_MISS;
            end
            ERR_PROT: begin
                code = is_write ? CW'(12'h0C0) : CW'(12'h0A0);
                vec  = VEC_OTHER;
            end
            ERR_FWR: begin
                code = CW'(12'h080);
                vec  = VEC_OTHER;
            end
            ERR_ADDR: begin
                code = is_write ? CW'(12'h100) : CW'(12'h0E0);
                vec  = VEC_OTHER;
            end
            default: begin
                code = '0;
                vec  = '0;
            end
        endcase
    end
endmodule

// File: rtl/dac_xlate_check.sv
module dac_xlate_check
    import dac_pkg::*;
#(
    parameter int AW      = 32,
    parameter int CW      = 12,
    parameter int VPN_LSB = 10,
    parameter int LINE_W  = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [AW-1:0]     req_vaddr,
    input  logic [1:0]        req_size,
    input  logic              req_write,
    input  logic              priv_mode,
    input  logic              xlate_en,
    input  logic              sq_priv_only,
    input  logic [AW-1:0]     sq_base0,
    input  logic [AW-1:0]     sq_base1,
    input  logic              tlb_hit,
    input  logic              tlb_multi,
    input  logic [AW-1:0]     tlb_paddr,
    input  logic [1:0]        tlb_prot,
    input  logic              tlb_dirty,
    output logic              tlb_use,
    output logic              rsp_valid,
    output logic [AW-1:0]     rsp_paddr,
    output logic              rsp_fault,
    output logic              rsp_multihit,
    output logic [CW-1:0]     rsp_code,
    output logic [CW-1:0]     rsp_vec,
    output logic [AW-1:0]     fault_addr,
    output logic [AW-VPN_LSB-1:0] fault_vpn
);
    localparam int VW = AW - VPN_LSB;

    typedef struct packed {
        logic          valid;
        logic          fault;
        logic          mhit;
        logic [AW-1:0] paddr;
        logic [CW-1:0] code;
        logic [CW-1:0] vec;
        logic [AW-1:0] fa;
        logic [VW-1:0] vpn;
    } state_t;

    state_t s_d, s_q;

    dac_route_e    route;
    dac_err_e      prot_err;
    dac_err_e      err_d;
    logic [CW-1:0] map_code, map_vec;
    logic [AW-1:0] line_addr;
    logic [AW-1:0] sq_base_sel;
    logic [AW-1:0] pa_d;

    dac_region #(.AW(AW)) u_region (
        .vaddr        (req_vaddr),
        .size         (req_size),
        .is_write     (req_write),
        .priv         (priv_mode),
        .sq_priv_only (sq_priv_only),
        .route        (route)
    );

    dac_prot u_prot (
        .hit      (tlb_hit),
        .multi    (tlb_multi),
        .prot     (tlb_prot),
        .dirty    (tlb_dirty),
        .priv     (priv_mode),
        .is_write (req_write),
        .err      (prot_err)
    );

    dac_exc_map #(.CW(CW)) u_map (
        .err      (err_d),
        .is_write (req_write),
        .code     (map_code),
        .vec      (map_vec)
    );

    always_comb begin
        line_addr   = {req_vaddr[AW-1:LINE_W], {LINE_W{1'b0}}};
        sq_base_sel = req_vaddr[LINE_W] ? sq_base1 : sq_base0;
        tlb_use     = req_valid && xlate_en && ((route == RT_TLB) || (route == RT_SQ));

        err_d = ERR_NONE;
        pa_d  = req_vaddr;
        case (route)
            RT_ERR:  err_d = ERR_ADDR;
            RT_PASS: pa_d  = req_vaddr;
            RT_TLB: begin
                if (xlate_en) begin
                    err_d = prot_err;
                    pa_d  = tlb_paddr;
                end
            end
            default: begin
                if (xlate_en) begin
                    err_d = prot_err;
                    pa_d  = {tlb_paddr[AW-1:LINE_W], {LINE_W{1'b0}}};
                end else begin
                    pa_d  = sq_base_sel + line_addr;
                end
            end
        endcase

        s_d       = s_q;
        s_d.valid = req_valid;
        s_d.fault = 1'b0;
        s_d.mhit  = 1'b0;
        s_d.paddr = '0;
        s_d.code  = '0;
        s_d.vec   = '0;
        if (req_valid) begin
            case (err_d)
                ERR_NONE: s_d.paddr = pa_d;
                ERR_MHIT: s_d.mhit  = 1'b1;
                default: begin
                    s_d.fault = 1'b1;
                    s_d.code  = map_code;
                    s_d.vec   = map_vec;
                end
            endcase
            if (err_d != ERR_NONE) begin
                s_d.fa  = req_vaddr;
                s_d.vpn = req_vaddr[AW-1:VPN_LSB];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign rsp_valid    = s_q.valid;
    assign rsp_fault    = s_q.fault;
    assign rsp_multihit = s_q.mhit;
    assign rsp_paddr    = s_q.paddr;
    assign rsp_code     = s_q.code;
    assign rsp_vec      = s_q.vec;
    assign fault_addr   = s_q.fa;
    assign fault_vpn    = s_q.vpn;

    // Alignment: a misaligned request always turns into a fault
    p_misalign_faults_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && ((req_size == 2'd1 && req_vaddr[0]) ||
                      (req_size == 2'd2 && req_vaddr[1:0] != 2'b00) ||
                      (req_size == 2'd3 && req_vaddr[2:0] != 3'b000)) |=> rsp_fault);

    p_raw_no_tlb_r3: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid && priv_mode && (req_vaddr[AW-1 -: 6] == PRIV_RAW_TAG) |-> !tlb_use);

    p_write_codes_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault && $past(req_write) |->
        (rsp_code == CW'(12'h060) || rsp_code == CW'(12'h0C0) ||
         rsp_code == CW'(12'h080) || rsp_code == CW'(12'h100)));

    p_read_codes_r9: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault && !$past(req_write) |->
        (rsp_code == CW'(12'h040) || rsp_code == CW'(12'h0A0) || rsp_code == CW'(12'h0E0)));

    p_vec_pairing_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_fault |-> ((rsp_vec == CW'(12'h400)) ==
                       (rsp_code == CW'(12'h040) || rsp_code == CW'(12'h060))));

    p_fault_latch_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_fault || rsp_multihit) |->
        (fault_addr == $past(req_vaddr)) && (fault_vpn == $past(req_vaddr[AW-1:VPN_LSB])));

    p_fault_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !rsp_fault && !rsp_multihit |-> $stable(fault_addr) && $stable(fault_vpn));

    p_mhit_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_multihit |-> !rsp_fault && rsp_code == '0 && rsp_vec == '0 && rsp_paddr == '0);

    p_valid_follows_r12: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> $past(req_valid));

endmodule

// File: tb/sim_dac_xlate_check.sv
module sim_dac_xlate_check;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] req_vaddr = '0;
    logic [1:0]  req_size = '0;
    logic        req_write = 1'b0;
    logic        priv_mode = 1'b0;
    logic        xlate_en = 1'b0;
    logic        sq_priv_only = 1'b0;
    logic [31:0] sq_base0 = 32'h0C00_0000;
    logic [31:0] sq_base1 = 32'h0D00_0000;
    logic        tlb_hit = 1'b0;
    logic        tlb_multi = 1'b0;
    logic [31:0] tlb_paddr = 32'h0123_4567;
    logic [1:0]  tlb_prot = '0;
    logic        tlb_dirty = 1'b0;
    logic        tlb_use;
    logic        rsp_valid;
    logic [31:0] rsp_paddr;
    logic        rsp_fault;
    logic        rsp_multihit;
    logic [11:0] rsp_code;
    logic [11:0] rsp_vec;
    logic [31:0] fault_addr;
    logic [21:0] fault_vpn;

    int n_run = 0;
    int n_fail = 0;
    logic [31:0] exp_fa = '0;

    always #5 clk = ~clk;

    dac_xlate_check u0 (.*);

    typedef struct packed {
        logic [31:0] va;
        logic [1:0]  sz;
        logic        wr, pv, xe, sp, hit, mh;
        logic [1:0]  pr;
        logic        dt;
        logic        ef, em;
        logic [31:0] ep;
        logic [11:0] ec, ev;
        logic [7:0]  rq;
    } vec_t;

    localparam int NV = 26;
    localparam vec_t VECS [NV] = '{
        // R1 / R9: misaligned halfword read
        '{32'h0000_1001, 2'd1, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b1,1'b0, 32'h0,          12'h0E0,12'h100, 8'd1},
        // R1 / R8: misaligned 8-byte write
        '{32'h0000_1004, 2'd3, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b1,1'b0, 32'h0,          12'h100,12'h100, 8'd1},
        // R1: byte at odd address is fine
        '{32'h0000_1003, 2'd0, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b0,1'b0, 32'h0123_4567, 12'h0,  12'h0,   8'd1},
        // R1: aligned 8-byte write
        '{32'h0000_1008, 2'd3, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b0,1'b0, 32'h0123_4567, 12'h0,  12'h0,   8'd1},
        // R2: user read with bit 31 set
        '{32'h8C00_0000, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b1,1'b0, 32'h0,          12'h0E0,12'h100, 8'd2},
        // R2 / R7: user store-queue write allowed, base0
        '{32'hE000_0040, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'hEC00_0040, 12'h0,  12'h0,   8'd2},
        // R7: address bit 5 selects base1
        '{32'hE000_0024, 2'd2, 1'b1,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'hED00_0020, 12'h0,  12'h0,   8'd7},
        // R7: byte store-queue write not word aligned
        '{32'hE000_0001, 2'd0, 1'b1,1'b1,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h100,12'h100, 8'd7},
        // R7: restricted window, user mode
        '{32'hE000_0000, 2'd2, 1'b1,1'b0,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h100,12'h100, 8'd7},
        // R7: restricted window, privileged mode
        '{32'hE000_0000, 2'd2, 1'b1,1'b1,1'b0,1'b1,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'hEC00_0000, 12'h0,  12'h0,   8'd7},
        // R7: translated store-queue write, low 5 bits cleared
        '{32'hE000_0080, 2'd2, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b1, 1'b0,1'b0, 32'h0123_4560, 12'h0,  12'h0,   8'd7},
        // R7 / R8: translated store-queue write, write not allowed
        '{32'hE000_0080, 2'd2, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd2,1'b1, 1'b1,1'b0, 32'h0,          12'h0C0,12'h100, 8'd7},
        // R3: privileged raw window passes through
        '{32'h7C00_1234, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'h7C00_1234, 12'h0,  12'h0,   8'd3},
        // R3 / R9: same address in user mode goes to TLB and misses
        '{32'h7C00_1234, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h040,12'h400, 8'd3},
        // R4: segment 100
        '{32'h8000_1000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'h8000_1000, 12'h0,  12'h0,   8'd4},
        // R4: segment 101 write
        '{32'hA000_0010, 2'd2, 1'b1,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'hA000_0010, 12'h0,  12'h0,   8'd4},
        // R4: segment 111
        '{32'hFF00_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'hFF00_0000, 12'h0,  12'h0,   8'd4},
        // R4: segment 110 is translated, miss
        '{32'hC000_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h040,12'h400, 8'd4},
        // R5: translation off passes through
        '{32'h0040_0000, 2'd2, 1'b0,1'b0,1'b0,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b0,1'b0, 32'h0040_0000, 12'h0,  12'h0,   8'd5},
        // R5 / R8: write miss
        '{32'h0040_0000, 2'd2, 1'b1,1'b0,1'b1,1'b0,1'b0,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h060,12'h400, 8'd5},
        // R6 / R9: user read of privileged page
        '{32'h0040_0000, 2'd2, 1'b0,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd1,1'b1, 1'b1,1'b0, 32'h0,          12'h0A0,12'h100, 8'd6},
        // R6: privileged read of the same page
        '{32'h0040_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd1,1'b1, 1'b0,1'b0, 32'h0123_4567, 12'h0,  12'h0,   8'd6},
        // R6 / R8: write to read-only page
        '{32'h0040_0000, 2'd2, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd2,1'b1, 1'b1,1'b0, 32'h0,          12'h0C0,12'h100, 8'd6},
        // R6 / R8: first write to clean page
        '{32'h0040_0000, 2'd2, 1'b1,1'b1,1'b1,1'b0,1'b1,1'b0, 2'd3,1'b0, 1'b1,1'b0, 32'h0,          12'h080,12'h100, 8'd6},
        // R6: protection wins over first write
        '{32'h0040_0000, 2'd2, 1'b1,1'b0,1'b1,1'b0,1'b1,1'b0, 2'd0,1'b0, 1'b1,1'b0, 32'h0,          12'h0C0,12'h100, 8'd6},
        // R11: multihit over hit
        '{32'h0040_0000, 2'd2, 1'b0,1'b1,1'b1,1'b0,1'b1,1'b1, 2'd3,1'b1, 1'b0,1'b1, 32'h0,          12'h0,  12'h0,   8'd11}
    };

    task automatic check(input bit ok, input string req, input string msg);
        n_run++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: %s", req, msg);
        end
    endtask

    task automatic drive(input vec_t v);
        @(negedge clk);
        req_valid    = 1'b1;
        req_vaddr    = v.va;
        req_size     = v.sz;
        req_write    = v.wr;
        priv_mode    = v.pv;
        xlate_en     = v.xe;
        sq_priv_only = v.sp;
        tlb_hit      = v.hit;
        tlb_multi    = v.mh;
        tlb_prot     = v.pr;
        tlb_dirty    = v.dt;
    endtask

    initial begin
        #400_000;
        n_fail++;
        $display("FAIL watchdog: run did not finish");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12: reset state
        check(rsp_valid == 0 && rsp_fault == 0 && rsp_multihit == 0 && rsp_paddr == 0 &&
              fault_addr == 0 && fault_vpn == 0, "R12",
              $sformatf("reset outputs valid=%0b fa=%h exp all 0", rsp_valid, fault_addr));
        rst_n = 1'b1;

        for (int i = 0; i < NV; i++) begin
            drive(VECS[i]);
            if (VECS[i].ef || VECS[i].em) exp_fa = VECS[i].va;
            @(negedge clk);
            check(rsp_valid && rsp_fault == VECS[i].ef && rsp_multihit == VECS[i].em &&
                  rsp_paddr == VECS[i].ep && rsp_code == VECS[i].ec && rsp_vec == VECS[i].ev,
                  $sformatf("R%0d vec %0d", VECS[i].rq, i),
                  $sformatf("got v=%0b f=%0b m=%0b pa=%h code=%h vec=%h exp f=%0b m=%0b pa=%h code=%h vec=%h",
                            rsp_valid, rsp_fault, rsp_multihit, rsp_paddr, rsp_code, rsp_vec,
                            VECS[i].ef, VECS[i].em, VECS[i].ep, VECS[i].ec, VECS[i].ev));
            // R10: fault registers track the last faulting address
            check(fault_addr == exp_fa && fault_vpn == exp_fa[31:10], "R10",
                  $sformatf("vec %0d fault_addr=%h vpn=%h exp %h/%h", i, fault_addr, fault_vpn,
                            exp_fa, exp_fa[31:10]));
        end

        // R3: raw window does not request the TLB
        drive(VECS[12]);
        #1;
        check(tlb_use == 1'b0, "R3", $sformatf("tlb_use=%0b exp 0", tlb_use));
        // R5: translated region requests the TLB
        drive(VECS[19]);
        #1;
        check(tlb_use == 1'b1, "R5", $sformatf("tlb_use=%0b exp 1", tlb_use));
        exp_fa = VECS[19].va;

        // R12: idle request gives no response and keeps fault registers
        @(negedge clk);
        req_valid = 1'b0;
        req_vaddr = 32'h0000_0003;
        req_size  = 2'd2;
        @(negedge clk);
        check(rsp_valid == 0 && rsp_fault == 0 && rsp_paddr == 0, "R12",
              $sformatf("idle valid=%0b fault=%0b exp 0/0", rsp_valid, rsp_fault));
        check(fault_addr == exp_fa, "R10",
              $sformatf("idle fault_addr=%h exp %h", fault_addr, exp_fa));

        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule